// File: doc/BRIEF.md
# Delay Code Tracking Controller

This block keeps a strobe delay element in step with a master delay-locked loop after the element's delay code has been frozen for manual margin work. Once the element stops taking codes straight from the loop, this controller watches the code the loop reports. It turns every change it sees into a series of single-step move pulses, each with a direction bit, so the frozen element follows the loop one step at a time.

Every adjustment sits inside a pause request. The pause rises first and is given a settle time. The controller then sends pulses, spaced apart, until its own record of the element's code equals the loop's code. After that it drops the pause. The controller also drives the element's load-enable line. With margin control on, load-enable is high and the element ignores new codes from the loop. With margin control off, load-enable is low, the element loads the loop code continuously, and the controller's tracked code simply follows the loop.

Top module: `code_track_top`

## Requirements
- R1: Output `loadEn` equals the `marginEn` input in every cycle, so that a high `marginEn` freezes the element and a low one lets it load continuously.
- R2: While `marginEn` is low, `pauseReq` and `moveStrobe` stay low, and `trackCode` copies the accepted loop code.
- R3: The loop code passes through two synchronizer flops. A value is accepted only when two consecutive synchronized samples are equal, so a value present for a single cycle never changes `trackCode` and never starts an adjustment.
- R4: With `marginEn` high, a difference of k steps between the accepted code and `trackCode` produces exactly k `moveStrobe` pulses, each one cycle wide.
- R5: During a pulse, `moveDir` is 1 when the accepted code is greater than `trackCode` and 0 when it is smaller. `moveDir` holds the same value in the cycle before each pulse.
- R6: `pauseReq` is high for at least SETTLE (default 3) cycles before the first pulse of an adjustment, and it is high during every pulse.
- R7: Any two pulses have at least GAP (default 2) cycles without a pulse between them.
- R8: While `marginEn` is high, `trackCode` changes only in the cycle after a pulse. It moves up by exactly one when `moveDir` was 1 and down by exactly one when it was 0.
- R9: After the codes match, `pauseReq` drops and stays low. A newly accepted code equal to `trackCode` raises neither pause nor pulse.
- R10: After reset, `pauseReq` and `moveStrobe` are low and `trackCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| marginEn | input | 1 | Margin control enable; high freezes the delay element |
| dllCode | input | CODE_W | Code reported by the delay-locked loop, asynchronous |
| loadEn | output | 1 | Load-enable control to the delay element |
| pauseReq | output | 1 | Pause request that brackets each adjustment |
| moveStrobe | output | 1 | One-cycle move pulse, one code step |
| moveDir | output | 1 | Move direction, 1 = increase delay |
| trackCode | output | CODE_W | Code the frozen element is taken to hold |

## Verification
The case that is hardest to reach from the ports is a full-scale swing. Moving from the lowest code to the highest, and back, needs hundreds of paced pulses, and spacing and direction setup must hold across all of them. The vector table drives these extreme jumps and a few small steps in both directions. A monitor counts every pulse and checks pause coverage, spacing, direction stability and the single-step change of `trackCode`. The glitch filter is reached by driving a new code for exactly one cycle between two stable values.

// File: rtl/code_track_pkg.sv
package code_track_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAUSE,
    ST_MOVE,
    ST_GAP,
    ST_UNPAUSE
  } trackState_t;

  typedef struct packed {
    logic loadTrack;
    logic stepEn;
    logic stepUp;
  } ctrlStrobe_t;

endpackage

// File: rtl/code_track_dp.sv
module code_track_dp
  import code_track_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] dllCode,
  input  ctrlStrobe_t       ctl,
  output logic              codeDiffer,
  output logic              codeUp,
  output logic [CODE_W-1:0] trackCode
);

  localparam int SYNC_STAGES = 2;

  logic [CODE_W-1:0] syncStage [SYNC_STAGES];
  logic [CODE_W-1:0] prevSample;
  logic [CODE_W-1:0] acceptCode;
  logic [CODE_W-1:0] trackReg;

  // two-flop synchronizer chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[i] <= '0;
          else       syncStage[i] <= dllCode;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[i] <= '0;
          else       syncStage[i] <= syncStage[i-1];
        end
      end
    end
  endgenerate

  // accept only values seen on two consecutive synchronized samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= '0;
      acceptCode <= '0;
    end else begin
      prevSample <= syncStage[SYNC_STAGES-1];
      if (syncStage[SYNC_STAGES-1] == prevSample)
        acceptCode <= prevSample;
    end
  end

  // tracked copy of the frozen element's code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trackReg <= '0;
    end else if (ctl.loadTrack) begin
      trackReg <= acceptCode;
    end else if (ctl.stepEn) begin
      if (ctl.stepUp) trackReg <= trackReg + CODE_W'(1);
      else            trackReg <= trackReg - CODE_W'(1);
    end
  end

  assign codeDiffer = (acceptCode != trackReg);
  assign codeUp     = (acceptCode > trackReg);
  assign trackCode  = trackReg;

endmodule

// File: rtl/code_track_ctrl.sv
module code_track_ctrl
  import code_track_pkg::*;
#(
  parameter int SETTLE = 3,
  parameter int GAP    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        marginEn,
  input  logic        codeDiffer,
  input  logic        codeUp,
  output ctrlStrobe_t ctl,
  output logic        pauseReq,
  output logic        moveStrobe,
  output logic        moveDir
);

  localparam int CNT_MAX = (SETTLE > GAP) ? SETTLE : GAP;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP - 1);

  trackState_t state;
  logic [CNT_W-1:0] waitCnt;
  logic dirReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      dirReg  <= 1'b0;
    end else if (!marginEn) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (codeDiffer) state <= ST_PAUSE;
        end
        ST_PAUSE: begin
          dirReg <= codeUp;
          if (!codeDiffer) begin
            state <= ST_UNPAUSE;
          end else if (waitCnt == SETTLE_LAST) begin
            if (dirReg == codeUp) state <= ST_MOVE;
          end else begin
            waitCnt <= waitCnt + CNT_W'(1);
          end
        end
        ST_MOVE: begin
          state   <= ST_GAP;
          waitCnt <= '0;
        end
        ST_GAP: begin
          dirReg <= codeUp;
          if (waitCnt == GAP_LAST) begin
            if (!codeDiffer)            state <= ST_UNPAUSE;
            else if (dirReg == codeUp)  state <= ST_MOVE;
          end else begin
            waitCnt <= waitCnt + CNT_W'(1);
          end
        end
        ST_UNPAUSE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadTrack = (state == ST_IDLE) && !marginEn;
    ctl.stepEn    = (state == ST_MOVE) && marginEn;
    ctl.stepUp    = dirReg;
  end

  assign pauseReq   = marginEn && (state == ST_PAUSE || state == ST_MOVE || state == ST_GAP);
  assign moveStrobe = ctl.stepEn;
  assign moveDir    = dirReg;

endmodule

// File: rtl/code_track_top.sv
module code_track_top
  import code_track_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SETTLE = 3,
  parameter int GAP    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              marginEn,
  input  logic [CODE_W-1:0] dllCode,
  output logic              loadEn,
  output logic              pauseReq,
  output logic              moveStrobe,
  output logic              moveDir,
  output logic [CODE_W-1:0] trackCode
);

  ctrlStrobe_t ctl;
  logic codeDiffer;
  logic codeUp;

  code_track_dp #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dllCode    (dllCode),
    .ctl        (ctl),
    .codeDiffer (codeDiffer),
    .codeUp     (codeUp),
    .trackCode  (trackCode)
  );

  code_track_ctrl #(.SETTLE(SETTLE), .GAP(GAP)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .marginEn   (marginEn),
    .codeDiffer (codeDiffer),
    .codeUp     (codeUp),
    .ctl        (ctl),
    .pauseReq   (pauseReq),
    .moveStrobe (moveStrobe),
    .moveDir    (moveDir)
  );

  assign loadEn = marginEn;

endmodule

// File: rtl/code_track_chk.sv
module code_track_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              marginEn,
  input logic              pauseReq,
  input logic              moveStrobe,
  input logic              moveDir,
  input logic [CODE_W-1:0] trackCode
);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !marginEn |-> (!pauseReq && !moveStrobe));

  assert_dir_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    moveStrobe |-> (moveDir == $past(moveDir)));

  assert_pause_cover_R6: assert property (@(posedge clk) disable iff (!rstN)
    moveStrobe |-> pauseReq);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    moveStrobe |=> !moveStrobe);

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(moveStrobe, 2) |-> !moveStrobe);

  assert_step_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    (moveStrobe && moveDir) |=> (trackCode == $past(trackCode) + CODE_W'(1)));

  assert_step_dn_R8: assert property (@(posedge clk) disable iff (!rstN)
    (moveStrobe && !moveDir) |=> (trackCode == $past(trackCode) - CODE_W'(1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (marginEn && !moveStrobe) |=> $stable(trackCode));

endmodule

bind code_track_top code_track_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .marginEn   (marginEn),
  .pauseReq   (pauseReq),
  .moveStrobe (moveStrobe),
  .moveDir    (moveDir),
  .trackCode  (trackCode)
);

// File: tb/sim_code_track_top.sv
`timescale 1ns/1ps
module sim_code_track_top;

  localparam int CODE_W = 8;
  localparam int SETTLE = 3;
  localparam int GAP    = 2;

  // entry: {code[7:0], pulses[8:0], dir}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'd5,   9'd5,   1'b1},
    {8'd2,   9'd3,   1'b0},
    {8'd2,   9'd0,   1'b0},
    {8'd255, 9'd253, 1'b1},
    {8'd0,   9'd255, 1'b0},
    {8'd128, 9'd128, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic marginEn = 1'b1;
  logic [CODE_W-1:0] dllCode = '0;
  logic loadEn, pauseReq, moveStrobe, moveDir;
  logic [CODE_W-1:0] trackCode;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  code_track_top #(.CODE_W(CODE_W), .SETTLE(SETTLE), .GAP(GAP)) u0 (
    .clk(clk), .rstN(rstN), .marginEn(marginEn), .dllCode(dllCode),
    .loadEn(loadEn), .pauseReq(pauseReq), .moveStrobe(moveStrobe),
    .moveDir(moveDir), .trackCode(trackCode)
  );

  // monitor: cumulative counters sampled away from the active edge
  int pulseTotal = 0, upTotal = 0, pauseTotal = 0;
  int dirErr = 0, pauseErr = 0, gapErr = 0, stepErr = 0, loadErr = 0;
  int pauseRun = 0, sinceLast = 100;
  logic prevDir = 1'b0, prevMove = 1'b0, prevMoveDir = 1'b0, prevMargin = 1'b0;
  logic [CODE_W-1:0] prevTrack = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (loadEn !== marginEn) loadErr++;
      pauseRun  = pauseReq ? pauseRun + 1 : 0;
      sinceLast = sinceLast + 1;
      if (pauseReq) pauseTotal++;
      if (prevMove) begin
        if (prevMoveDir && trackCode !== prevTrack + 8'd1) stepErr++;
        if (!prevMoveDir && trackCode !== prevTrack - 8'd1) stepErr++;
      end else if (prevMargin && marginEn && trackCode !== prevTrack) begin
        stepErr++;
      end
      if (moveStrobe) begin
        pulseTotal++;
        if (moveDir) upTotal++;
        if (moveDir !== prevDir) dirErr++;
        if (pauseRun < SETTLE + 1) pauseErr++;
        if (sinceLast < GAP + 1) gapErr++;
        sinceLast = 0;
      end
      prevDir     = moveDir;
      prevMove    = moveStrobe;
      prevMoveDir = moveDir;
      prevMargin  = marginEn;
      prevTrack   = trackCode;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, u0c, q0, k;
    logic [CODE_W-1:0] code;
    // reset state R10
    cycles(4);
    check(pauseReq == 1'b0, "R10 pause in reset", int'(pauseReq), 0);
    check(moveStrobe == 1'b0, "R10 move in reset", int'(moveStrobe), 0);
    @(posedge clk); #1 rstN = 1'b1;
    cycles(2);
    check(trackCode == 8'd0, "R10 trackCode after reset", int'(trackCode), 0);
    check(loadEn == 1'b1, "R1 loadEn with margin on", int'(loadEn), 1);

    // vector table: R4 R5 R6 R7 R8 R9
    foreach (VEC[i]) begin
      code = VEC[i][17:10];
      k    = int'(VEC[i][9:1]);
      p0 = pulseTotal; u0c = upTotal; q0 = pauseTotal;
      @(posedge clk); #1 dllCode = code;
      cycles(14 + 4 * k);
      check(pulseTotal - p0 == k, "R4 pulse count", pulseTotal - p0, k);
      check(upTotal - u0c == (VEC[i][0] ? k : 0), "R5 direction of pulses",
            upTotal - u0c, VEC[i][0] ? k : 0);
      check(trackCode == code, "R8 final trackCode", int'(trackCode), int'(code));
      check(pauseReq == 1'b0, "R9 pause released", int'(pauseReq), 0);
      if (k == 0)
        check(pauseTotal == q0, "R9 no pause on equal code", pauseTotal - q0, 0);
    end
    check(dirErr == 0, "R5 dir stable before pulse", dirErr, 0);
    check(pauseErr == 0, "R6 pause lead and coverage", pauseErr, 0);
    check(gapErr == 0, "R7 pulse spacing", gapErr, 0);
    check(stepErr == 0, "R8 single step per pulse", stepErr, 0);

    // one-cycle glitch R3
    p0 = pulseTotal; q0 = pauseTotal;
    @(posedge clk); #1 dllCode = 8'd9;
    @(posedge clk); #1 dllCode = 8'd128;
    cycles(20);
    check(pulseTotal == p0, "R3 glitch pulses", pulseTotal - p0, 0);
    check(pauseTotal == q0, "R3 glitch pause", pauseTotal - q0, 0);
    check(trackCode == 8'd128, "R3 glitch trackCode", int'(trackCode), 128);

    // continuous load with margin off R1 R2
    p0 = pulseTotal; q0 = pauseTotal;
    @(posedge clk); #1 marginEn = 1'b0; dllCode = 8'd77;
    cycles(2);
    check(loadEn == 1'b0, "R1 loadEn with margin off", int'(loadEn), 0);
    cycles(6);
    check(trackCode == 8'd77, "R2 trackCode follows", int'(trackCode), 77);
    check(pulseTotal == p0, "R2 no pulses", pulseTotal - p0, 0);
    check(pauseTotal == q0, "R2 no pause", pauseTotal - q0, 0);

    // re-enable and move a few steps down from the loaded code R4 R5
    @(posedge clk); #1 marginEn = 1'b1;
    cycles(4);
    p0 = pulseTotal; u0c = upTotal;
    @(posedge clk); #1 dllCode = 8'd74;
    cycles(30);
    check(pulseTotal - p0 == 3, "R4 pulses after reload", pulseTotal - p0, 3);
    check(upTotal == u0c, "R5 downward after reload", upTotal - u0c, 0);
    check(trackCode == 8'd74, "R8 trackCode after reload", int'(trackCode), 74);
    check(loadErr == 0, "R1 loadEn tracks marginEn", loadErr, 0);
    check(stepErr == 0 && gapErr == 0 && dirErr == 0, "R7 final monitor", stepErr + gapErr + dirErr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule